// File: doc/BRIEF.md
# Privileged-Space Address Mapping Unit

This block turns a 32-bit virtual address into a physical address together with cacheable and write-through flags. It serves a processor that has two addressing modes. After reset it runs in the narrow mode. In that mode the two privileged direct-mapped windows reach physical memory by dropping the top three address bits, and each window has a fixed cache policy. When the extended-mode enable is set, those two windows instead look up a small, fully associative table that software loads. Each table entry supplies the upper three physical bits and the cache policy for one 512 MB window.

The other areas either pass through unchanged or take the physical page number from an external page-table lookup, depending on the translation-enable input. The control-register region at the very top of the map always comes out with its upper three physical bits set. A request is answered one cycle later. The answer is either a valid translation or a one-cycle miss pulse, which leaves the previous result on the outputs.

Top module: `priv_map_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pa_vld`, `miss` and `cfg_err` are 0 and `pa` is 0. The internal mode register clears to narrow mode. `ext_en` is sampled at each clock edge, and a request uses the value sampled at the previous edge.
- R2: In narrow mode, a request in window 1 (va[31:29]=3'b100) returns pa = va with bits [31:29] cleared, `pa_c`=1 and `pa_wt`=0.
- R3: In narrow mode, a request in window 2 (va[31:29]=3'b101) returns pa = va with bits [31:29] cleared, `pa_c`=0 and `pa_wt`=0.
- R4: In extended mode, a window 1 or window 2 request that hits a valid entry whose 3-bit tag equals va[31:29] returns pa = {entry ppn, va[28:0]} and takes `pa_c` and `pa_wt` from the entry. This holds whatever the value of `xlat_en`.
- R5: In extended mode, a window 1 or window 2 request with no hit gives `miss`=1 and `pa_vld`=0 for exactly one cycle. `pa`, `pa_c` and `pa_wt` keep their previous values.
- R6: A valid entry whose tag bits [2:1] are not 2'b10 never hits. `cfg_err` is 1 whenever at least one such entry is stored. It is visible in the cycle after the write edge.
- R7: In extended mode with `xlat_en`=0, a request in the user/low areas (va[31:29] < 3'b100) or in window 3 (3'b110) returns pa = va with `pa_c`=1 and `pa_wt`=0. A request in the top area (3'b111) returns pa = va with `pa_c`=0 and `pa_wt`=0.
- R8: With `xlat_en`=1, a request in the user/low areas or in window 3 returns pa = {`pt_ppn`, va[11:0]}, `pa_c`=`pt_c` and `pa_wt`=`pt_wt`. Top-area requests still pass through as in R7.
- R9: In narrow mode, every request outside windows 1 and 2 follows R7/R8, except that pa[31:29] is cleared.
- R10: A request with va[31:26]=6'h3F always returns pa[31:29]=3'b111 with `pa_vld`=1, in either mode and for either value of `xlat_en`.
- R11: The outputs update at the clock edge that samples `req_vld`. A write is seen by lookups from the next edge onward, so a lookup in the same cycle as the write sees the old contents. When several entries hit, the lowest index wins.
- R12: In a cycle after one with `req_vld`=0, `pa_vld` and `miss` are 0 and `pa` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Extended 32-bit mode enable |
| xlat_en | input | 1 | Page-table translation enable for non-window areas |
| req_vld | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address |
| pt_ppn | input | PPN_W (20) | Page-table physical page number |
| pt_c | input | 1 | Page-table cacheable flag |
| pt_wt | input | 1 | Page-table write-through flag |
| wr_en | input | 1 | Table entry write strobe |
| wr_idx | input | IDX_W (4) | Entry index to write |
| wr_vld | input | 1 | Valid bit to store |
| wr_vpn | input | 3 | Virtual 512 MB tag (va[31:29]) |
| wr_ppn | input | 3 | Physical 512 MB frame (pa[31:29]) |
| wr_c | input | 1 | Entry cacheable flag |
| wr_wt | input | 1 | Entry write-through flag |
| pa_vld | output | 1 | Translation result valid |
| pa | output | 32 | Physical address |
| pa_c | output | 1 | Cacheable |
| pa_wt | output | 1 | Write-through |
| miss | output | 1 | Table miss pulse |
| cfg_err | output | 1 | A stored valid entry has an illegal tag |

## Verification
Directed addresses go to each window in both modes. A narrow-mode request to window 1 and one to window 2 can only differ in the cache flag, so that pair isolates the fixed policy. The same table hit is repeated with translation on and off, which shows that the windows ignore `xlat_en`. An empty table, two overlapping entries and a write issued in the same cycle as its lookup separate the miss behaviour, the priority order and the write-visibility timing. Random addresses are then mixed with random table writes, some carrying illegal tags, and random mode and translation settings. Because the bench regenerates the page-table number for every request, it exposes any mix-up between the pass-through, page-table and table paths or a wrong pick of the upper bits.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int ADDR_W = 32;
  localparam int SEG_W  = 3;

  localparam logic [1:0] PRIV_TAG = 2'b10;
  localparam logic [5:0] CREG_TOP = 6'h3F;

  typedef enum logic [2:0] {
    AR_LOW = 3'd0,
    AR_W1  = 3'd1,
    AR_W2  = 3'd2,
    AR_W3  = 3'd3,
    AR_TOP = 3'd4
  } area_e;

  typedef struct packed {
    logic [SEG_W-1:0] vpn;
    logic [SEG_W-1:0] ppn;
    logic             c;
    logic             wt;
  } ment_t;
endpackage

// File: rtl/pmap_area_dec.sv
module pmap_area_dec
  import pmap_pkg::*;
(
  input  logic [5:0] va_top,
  output area_e      area,
  output logic       creg
);
  always_comb begin
    unique case (va_top[5:3])
      3'b100:  area = AR_W1;
      3'b101:  area = AR_W2;
      3'b110:  area = AR_W3;
      3'b111:  area = AR_TOP;
      default: area = AR_LOW;
    endcase
    creg = (va_top == CREG_TOP);
  end
endmodule

// File: rtl/pmap_cam.sv
module pmap_cam
  import pmap_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  ment_t            wr_ent,
  input  logic [SEG_W-1:0] lk_seg,
  output logic             hit,
  output ment_t            hit_ent,
  output logic             cfg_err
);
  // payload kept without reset so it can sit in plain storage; valid bits reset
  ment_t            tbl [N_ENT];
  logic [N_ENT-1:0] vld_q;
  logic [N_ENT-1:0] mvec;
  logic [N_ENT-1:0] bad;
  logic [IDX_W-1:0] sel;

  always_ff @(posedge clk) begin
    if (wr_en) tbl[wr_idx] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (rst)        vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_vld;
  end

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
    assign bad[gi]  = vld_q[gi] && (tbl[gi].vpn[SEG_W-1:SEG_W-2] != PRIV_TAG);
    assign mvec[gi] = vld_q[gi] && !bad[gi] && (tbl[gi].vpn == lk_seg);
  end

  always_comb begin
    sel = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (mvec[i]) sel = IDX_W'(i);
    end
  end

  assign hit     = |mvec;
  assign hit_ent = tbl[sel];
  assign cfg_err = |bad;
endmodule

// File: rtl/priv_map_unit.sv
module priv_map_unit
  import pmap_pkg::*;
#(
  parameter int N_ENT    = 16,
  parameter int PG_OFS_W = 12,
  localparam int IDX_W   = $clog2(N_ENT),
  localparam int PPN_W   = ADDR_W - PG_OFS_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_en,
  input  logic              xlat_en,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [PPN_W-1:0]  pt_ppn,
  input  logic              pt_c,
  input  logic              pt_wt,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_vld,
  input  logic [SEG_W-1:0]  wr_vpn,
  input  logic [SEG_W-1:0]  wr_ppn,
  input  logic              wr_c,
  input  logic              wr_wt,
  output logic              pa_vld,
  output logic [ADDR_W-1:0] pa,
  output logic              pa_c,
  output logic              pa_wt,
  output logic              miss,
  output logic              cfg_err
);
  localparam int SEG_LO = ADDR_W - SEG_W;

  logic              mode_q;
  area_e             area;
  logic              creg;
  logic              hit;
  ment_t             hit_ent;
  ment_t             wr_ent;
  logic [ADDR_W-1:0] nx_pa;
  logic              nx_c, nx_wt, nx_ok, in_win;

  assign wr_ent = '{vpn: wr_vpn, ppn: wr_ppn, c: wr_c, wt: wr_wt};

  pmap_area_dec u_dec (
    .va_top (req_va[ADDR_W-1:ADDR_W-6]),
    .area   (area),
    .creg   (creg)
  );

  pmap_cam #(.N_ENT(N_ENT)) u_cam (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_vld  (wr_vld),
    .wr_ent  (wr_ent),
    .lk_seg  (req_va[ADDR_W-1:SEG_LO]),
    .hit     (hit),
    .hit_ent (hit_ent),
    .cfg_err (cfg_err)
  );

  assign in_win = (area == AR_W1) || (area == AR_W2);

  always_comb begin
    nx_pa = req_va;
    nx_c  = 1'b0;
    nx_wt = 1'b0;
    nx_ok = 1'b1;
    unique case (area)
      AR_W1, AR_W2: begin
        if (mode_q) begin
          nx_ok = hit;
          nx_pa = {hit_ent.ppn, req_va[SEG_LO-1:0]};
          nx_c  = hit_ent.c;
          nx_wt = hit_ent.wt;
        end else begin
          nx_pa = {{SEG_W{1'b0}}, req_va[SEG_LO-1:0]};
          nx_c  = (area == AR_W1);
        end
      end
      AR_TOP: nx_pa = req_va;
      default: begin
        if (xlat_en) begin
          nx_pa = {pt_ppn, req_va[PG_OFS_W-1:0]};
          nx_c  = pt_c;
          nx_wt = pt_wt;
        end else begin
          nx_c  = 1'b1;
        end
      end
    endcase
    if (!mode_q && !in_win) nx_pa[ADDR_W-1:SEG_LO] = '0;
    if (creg)               nx_pa[ADDR_W-1:SEG_LO] = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      pa_vld <= 1'b0;
      miss   <= 1'b0;
      pa     <= '0;
      pa_c   <= 1'b0;
      pa_wt  <= 1'b0;
    end else begin
      mode_q <= ext_en;
      pa_vld <= req_vld && nx_ok;
      miss   <= req_vld && !nx_ok;
      if (req_vld && nx_ok) begin
        pa    <= nx_pa;
        pa_c  <= nx_c;
        pa_wt <= nx_wt;
      end
    end
  end
endmodule

// File: rtl/pmap_chk.sv
module pmap_chk (
  input logic        clk,
  input logic        rst,
  input logic        mode_q,
  input logic        req_vld,
  input logic [31:0] req_va,
  input logic        pa_vld,
  input logic [31:0] pa,
  input logic        pa_c,
  input logic        miss
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pa_vld && !miss));

  p_w2_uncached_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_vld && !mode_q && req_va[31:29] == 3'b101)
      |-> (pa_vld && !pa_c && pa[31:29] == 3'b000));

  p_miss_hold_r5: assert property (@(posedge clk) disable iff (rst)
    miss |-> $stable(pa));

  p_miss_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(miss && pa_vld));

  p_creg_top_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_vld && req_va[31:26] == 6'h3F)
      |-> (pa_vld && pa[31:29] == 3'b111));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    $past(!req_vld) |-> (!pa_vld && !miss));
endmodule

bind priv_map_unit pmap_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode_q  (mode_q),
  .req_vld (req_vld),
  .req_va  (req_va),
  .pa_vld  (pa_vld),
  .pa      (pa),
  .pa_c    (pa_c),
  .miss    (miss)
);

// File: tb/sim_priv_map_unit.sv
`timescale 1ns/1ps
module sim_priv_map_unit;
  localparam int N_ENT = 16;
  localparam int PPN_W = 20;

  typedef struct packed {
    logic        ok;
    logic [31:0] pa;
    logic        c;
    logic        wt;
  } res_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_en = 1'b0, xlat_en = 1'b0, req_vld = 1'b0;
  logic [31:0] req_va = '0;
  logic [PPN_W-1:0] pt_ppn = '0;
  logic pt_c = 1'b0, pt_wt = 1'b0;
  logic wr_en = 1'b0, wr_vld = 1'b0, wr_c = 1'b0, wr_wt = 1'b0;
  logic [3:0] wr_idx = '0;
  logic [2:0] wr_vpn = '0, wr_ppn = '0;
  logic pa_vld, pa_c, pa_wt, miss, cfg_err;
  logic [31:0] pa;

  int total = 0;
  int bad = 0;

  logic       m_vld [N_ENT];
  logic [2:0] m_vpn [N_ENT];
  logic [2:0] m_ppn [N_ENT];
  logic       m_c   [N_ENT];
  logic       m_wt  [N_ENT];
  logic [31:0] prev_pa = '0;
  logic prev_c = 1'b0, prev_wt = 1'b0;
  logic cur_mode = 1'b0, cur_xlat = 1'b0;

  always #10 clk = ~clk;

  priv_map_unit u0 (
    .clk(clk), .rst(rst), .ext_en(ext_en), .xlat_en(xlat_en),
    .req_vld(req_vld), .req_va(req_va), .pt_ppn(pt_ppn), .pt_c(pt_c), .pt_wt(pt_wt),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld), .wr_vpn(wr_vpn),
    .wr_ppn(wr_ppn), .wr_c(wr_c), .wr_wt(wr_wt),
    .pa_vld(pa_vld), .pa(pa), .pa_c(pa_c), .pa_wt(pa_wt), .miss(miss), .cfg_err(cfg_err)
  );

  task automatic chk(input logic cond, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic res_t model(input logic [31:0] va, input logic mode, input logic xl,
                                 input logic [PPN_W-1:0] ppn, input logic pc, input logic pw);
    res_t r;
    logic [2:0] seg = va[31:29];
    logic win = (seg == 3'b100) || (seg == 3'b101);
    logic found = 1'b0;
    r = '{ok: 1'b1, pa: va, c: 1'b0, wt: 1'b0};
    if (win) begin
      if (mode) begin
        for (int i = 0; i < N_ENT; i++) begin
          if (!found && m_vld[i] && m_vpn[i][2:1] == 2'b10 && m_vpn[i] == seg) begin
            found = 1'b1;
            r.pa = {m_ppn[i], va[28:0]};
            r.c = m_c[i];
            r.wt = m_wt[i];
          end
        end
        r.ok = found;
      end else begin
        r.pa = {3'b000, va[28:0]};
        r.c = (seg == 3'b100);
      end
    end else if (seg != 3'b111) begin
      if (xl) begin
        r.pa = {ppn, va[11:0]};
        r.c = pc;
        r.wt = pw;
      end else r.c = 1'b1;
    end
    if (!mode && !win) r.pa[31:29] = 3'b000;
    if (va[31:26] == 6'h3F) r.pa[31:29] = 3'b111;
    return r;
  endfunction

  function automatic logic exp_cfg();
    logic e = 1'b0;
    for (int i = 0; i < N_ENT; i++) if (m_vld[i] && m_vpn[i][2:1] != 2'b10) e = 1'b1;
    return e;
  endfunction

  task automatic set_mode(input logic m, input logic x);
    @(negedge clk);
    ext_en = m; xlat_en = x;
    @(negedge clk);
    cur_mode = m; cur_xlat = x;
  endtask

  task automatic put(input int idx, input logic v, input logic [2:0] vpn,
                     input logic [2:0] ppn, input logic c, input logic wt);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vld = v; wr_vpn = vpn; wr_ppn = ppn; wr_c = c; wr_wt = wt;
    @(negedge clk);
    wr_en = 1'b0;
    m_vld[idx] = v; m_vpn[idx] = vpn; m_ppn[idx] = ppn; m_c[idx] = c; m_wt[idx] = wt;
    chk(cfg_err == exp_cfg(), "R6 cfg_err", {31'd0, cfg_err}, {31'd0, exp_cfg()});
  endtask

  task automatic check_res(input res_t e, input string tag);
    if (e.ok) begin
      chk(pa_vld && !miss, tag, {30'd0, pa_vld, miss}, 32'h2);
      chk(pa == e.pa, tag, pa, e.pa);
      chk({pa_c, pa_wt} == {e.c, e.wt}, tag, {30'd0, pa_c, pa_wt}, {30'd0, e.c, e.wt});
      prev_pa = e.pa; prev_c = e.c; prev_wt = e.wt;
    end else begin
      chk(!pa_vld && miss, {tag, " miss"}, {30'd0, pa_vld, miss}, 32'h1);
      chk(pa == prev_pa && pa_c == prev_c && pa_wt == prev_wt, {tag, " hold"}, pa, prev_pa);
    end
  endtask

  task automatic look(input logic [31:0] va, input string tag);
    res_t e;
    @(negedge clk);
    req_vld = 1'b1; req_va = va;
    pt_ppn = PPN_W'($urandom); pt_c = 1'($urandom); pt_wt = 1'($urandom);
    e = model(va, cur_mode, cur_xlat, pt_ppn, pt_c, pt_wt);
    @(negedge clk);
    req_vld = 1'b0;
    check_res(e, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    res_t e;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N_ENT; i++) begin
      m_vld[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_c[i] = 1'b0; m_wt[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(!pa_vld && !miss && !cfg_err && pa == 0, "R1 in reset", pa, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pa_vld && !miss && !cfg_err && pa == 0, "R1 after reset", pa, 32'h0);

    // narrow mode
    look(32'h8123_4567, "R2 narrow w1");
    look(32'hA765_4321, "R3 narrow w2");
    look(32'h4000_1000, "R9 narrow low");
    look(32'hFF00_0010, "R10 narrow creg");
    set_mode(1'b0, 1'b1);
    look(32'hC000_5123, "R9 narrow xlat");
    look(32'hFD00_0000, "R10 narrow xlat creg");
    @(negedge clk);
    chk(!pa_vld && !miss && pa == prev_pa, "R12 idle", pa, prev_pa);

    // extended mode
    set_mode(1'b1, 1'b0);
    look(32'h8000_0040, "R5 empty miss");
    put(3, 1'b1, 3'b100, 3'b011, 1'b1, 1'b1);
    look(32'h8000_0040, "R4 hit xlat0");
    set_mode(1'b1, 1'b1);
    look(32'h8ABC_0040, "R4 hit xlat1");
    put(5, 1'b1, 3'b100, 3'b111, 1'b0, 1'b0);
    look(32'h8000_0100, "R11 lowest index");
    put(7, 1'b1, 3'b011, 3'b001, 1'b1, 1'b0);
    look(32'h6000_0000, "R8 low xlat");
    put(7, 1'b0, 3'b011, 3'b001, 1'b1, 1'b0);

    // same-cycle write and lookup, then visible next cycle
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd0; wr_vld = 1'b1; wr_vpn = 3'b101; wr_ppn = 3'b001;
    wr_c = 1'b1; wr_wt = 1'b0;
    req_vld = 1'b1; req_va = 32'hA000_0004;
    e = model(32'hA000_0004, 1'b1, 1'b1, pt_ppn, pt_c, pt_wt);
    @(negedge clk);
    wr_en = 1'b0;
    m_vld[0] = 1'b1; m_vpn[0] = 3'b101; m_ppn[0] = 3'b001; m_c[0] = 1'b1; m_wt[0] = 1'b0;
    check_res(e, "R11 same-cycle write");
    e = model(32'hA000_0004, 1'b1, 1'b1, pt_ppn, pt_c, pt_wt);
    @(negedge clk);
    req_vld = 1'b0;
    check_res(e, "R11 next-cycle hit");

    look(32'hE000_0100, "R8 top passthrough");
    look(32'hFFFF_FFF0, "R10 ext creg");
    set_mode(1'b1, 1'b0);
    look(32'hC000_0000, "R7 w3 passthrough");
    look(32'hE800_0000, "R7 top passthrough");
    look(32'h1234_5678, "R7 low passthrough");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int k = int'($urandom % 16);
      if (it % 60 == 0) set_mode(1'($urandom), 1'($urandom));
      if (k == 0) begin
        logic [2:0] vp;
        vp = ($urandom % 8 == 0) ? 3'($urandom) : {2'b10, 1'($urandom)};
        put(int'($urandom % N_ENT), ($urandom % 4) != 0, vp, 3'($urandom),
            1'($urandom), 1'($urandom));
      end else begin
        logic [31:0] va;
        va = $urandom;
        if (k < 8) va[31:30] = 2'b10;
        else if (k == 8) va[31:26] = 6'h3F;
        look(va, (k < 8) ? "R4 random window" : (k == 8) ? "R10 random creg" : "R8 random other");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule